// File: doc/BRIEF.md
# Prioritized System Interrupt Controller

This block gathers a set of level-sensitive system interrupt sources and presents them to a processor on two separate request lines. The highest-numbered source is not an input. It belongs to an interval timer built into the block. All other sources form a general group that drives the first request line. The timer drives the second request line on its own, so a timer interrupt can be serviced at a different processor priority than device interrupts.

Software reaches the block through a single-cycle register port with four word addresses. Address 0 holds the enable mask. Address 1 is a priority vector port: it encodes the lowest-numbered pending group source, and any access to it silences the group request line. Address 2 holds the timer reload value. Address 3 is the timer status port: it acknowledges one timer expiry and restarts the count. The timer advances only on cycles where the tick-enable input is high, so the integrator chooses the time base. Expiries that software has not yet acknowledged are counted in a saturating counter. The timer request stays raised until software has drained that counter.

Register read data is combinational. It is valid in the same cycle as a read access. Both request lines are registered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: irq_group is registered. At a clock edge where the masked group state (src_level AND mask bits 0..NSRC-2) differs from its value in the previous cycle, and no vector access is present, irq_group becomes 1 if any masked group bit is set and 0 otherwise.
- R2: irq_timer is registered. At each edge it takes the value of the timer request flag ANDed with mask bit NSRC-1 (bit 15 by default), both as they stood before that edge.
- R3: A write to address 0 loads the mask from acc_wdata[NSRC-1:0], and a read of address 0 returns it. When the masked group state does not change, irq_group holds its value, whether or not the mask was written.
- R4: A read of address 1 returns ((index of the lowest-numbered set bit of src_level) + 1) shifted left by 2. It returns 0 when no group source is set. The mask does not affect this value, and the timer source is never reported.
- R5: Any access to address 1, read or write, drives irq_group to 0 at the next edge. irq_group stays 0 until the masked group state changes again.
- R6: A write to address 2 loads both the reload value and the current count from acc_wdata[CNT_W-1:0]. A read of address 2 returns the reload value.
- R7: On a tick_en cycle with a nonzero reload value and no access to addresses 2 or 3, a count above 1 decrements. A count of 1 or 0 is instead reloaded, and the expiry counter is incremented.
- R8: Any access to address 3 returns the current count on a read. It also clears the timer request flag, decrements the expiry counter if that counter is nonzero, and reloads the count from the reload value. The tick in that cycle is ignored.
- R9: The timer request flag is set at an edge where the expiry counter is nonzero, the reload value is nonzero and mask bit TMR_GATE_BIT (bit 1 by default) is set. Once set, only an access to address 3 clears it.
- R10: The expiry counter saturates at 2^PEND_W-1. Further expiries are lost, so exactly that many acknowledgements drain it.
- R11: Reset (rst_n low, asynchronous) clears the mask, reload value, count, expiry counter, request flag and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NSRC-1 | Level-sensitive group sources, bit i is source i |
| tick_en | input | 1 | Timer time-base strobe |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Word address: 0 mask, 1 vector, 2 reload, 3 status |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, valid in the cycle of a read access, 0 otherwise |
| irq_group | output | 1 | Request line for the general group |
| irq_timer | output | 1 | Request line for the interval timer |

## Verification
The bench builds the block with 16 sources, a 16-bit count and data path, and a 3-bit expiry counter. The narrow expiry counter brings saturation within reach of a few dozen ticks: ten expiries collapse to seven, and exactly seven acknowledgements then drain them. Small reload values let many expiry, acknowledge and reload interleavings occur, including ticks that land in the same cycle as a status access. These cases appear both in directed sequences and in a long pseudo-random run compared against a behavioural model on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   typedef enum logic [1:0] {
      RSEL_MASK   = 2'd0,
      RSEL_VECTOR = 2'd1,
      RSEL_RELOAD = 2'd2,
      RSEL_STATUS = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_interval_timer.sv
module irq_interval_timer #(
   parameter int CNT_W  = 16,
   parameter int PEND_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload_wr,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             status_acc,
   input  logic             gate_en,
   output logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] count_q,
   output logic             req_q
);
   localparam logic [PEND_W-1:0] PEND_MAX = '1;
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   if (CNT_W < 2)  begin : g_bad_cnt  $error("CNT_W too small");  end
   if (PEND_W < 1) begin : g_bad_pend $error("PEND_W too small"); end

   logic [PEND_W-1:0] pend_q;
   logic              run, expire;

   assign run    = tick && (reload_q != '0) && !reload_wr && !status_acc;
   assign expire = run && (count_q <= CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         count_q  <= '0;
      end else if (reload_wr) begin
         reload_q <= reload_val;
         count_q  <= reload_val;
      end else if (status_acc || expire) begin
         count_q  <= reload_q;
      end else if (run) begin
         count_q  <= count_q - CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else if (status_acc && pend_q != '0)
         pend_q <= pend_q - 1'b1;
      else if (expire && pend_q != PEND_MAX)
         pend_q <= pend_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_q <= 1'b0;
      else if (status_acc)
         req_q <= 1'b0;
      else if (pend_q != '0 && reload_q != '0 && gate_en)
         req_q <= 1'b1;
   end

   assert_status_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status_acc |=> !req_q);
   assert_reload_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reload_wr |=> (reload_q == $past(reload_val)) && (count_q == $past(reload_val)));
   assert_pend_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == PEND_MAX && !status_acc) |=> pend_q == PEND_MAX);
   assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !status_acc) |=> req_q);
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
   parameter int NGRP  = 15,
   parameter int VEC_W = $clog2(NGRP + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NGRP-1:0] src,
   input  logic [NGRP-1:0] en,
   input  logic            vec_acc,
   output logic            irq_a,
   output logic [VEC_W-1:0] vec_code
);
   if (NGRP < 1) begin : g_bad_ngrp $error("NGRP must be positive"); end
   if ((1 << VEC_W) < NGRP + 1) begin : g_bad_vecw $error("VEC_W too narrow"); end

   logic [NGRP-1:0] masked, masked_q;

   for (genvar i = 0; i < NGRP; i++) begin : g_mask
      assign masked[i] = src[i] & en[i];
   end

   always_comb begin
      vec_code = '0;
      for (int i = NGRP - 1; i >= 0; i--) begin
         if (src[i]) vec_code = VEC_W'(i + 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         masked_q <= '0;
         irq_a    <= 1'b0;
      end else begin
         masked_q <= masked;
         if (vec_acc)
            irq_a <= 1'b0;
         else if (masked != masked_q)
            irq_a <= |masked;
      end
   end

   assert_vec_silences_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_acc |=> !irq_a);
   assert_hold_unchanged_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_acc && masked == masked_q) |=> $stable(irq_a));
   assert_follow_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_acc && masked != masked_q) |=> irq_a == $past(|(src & en)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NSRC         = 16,
   parameter int CNT_W        = 16,
   parameter int PEND_W       = 8,
   parameter int DATA_W       = 32,
   parameter int TMR_GATE_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-2:0]   src_level,
   input  logic              tick_en,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [1:0]        acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              irq_group,
   output logic              irq_timer
);
   import irq_ctrl_pkg::*;

   localparam int NGRP  = NSRC - 1;
   localparam int VEC_W = $clog2(NGRP + 1);
   localparam int TMR_BIT = NSRC - 1;

   if (NSRC < 2)                begin : g_bad_nsrc $error("NSRC must be at least 2"); end
   if (DATA_W < NSRC)           begin : g_bad_dw1  $error("DATA_W below NSRC"); end
   if (DATA_W < CNT_W)          begin : g_bad_dw2  $error("DATA_W below CNT_W"); end
   if (DATA_W < VEC_W + 2)      begin : g_bad_dw3  $error("DATA_W below vector width"); end
   if (TMR_GATE_BIT >= NSRC)    begin : g_bad_gate $error("TMR_GATE_BIT out of range"); end

   reg_sel_e          sel;
   logic              rd, mask_wr, reload_wr, status_acc, vec_acc;
   logic [NSRC-1:0]   mask_q;
   logic [CNT_W-1:0]  reload_q, count_q;
   logic              tmr_req;
   logic [VEC_W-1:0]  vec_code;

   assign sel        = reg_sel_e'(acc_addr);
   assign rd         = acc_en && !acc_wr;
   assign mask_wr    = acc_en && acc_wr && (sel == RSEL_MASK);
   assign reload_wr  = acc_en && acc_wr && (sel == RSEL_RELOAD);
   assign status_acc = acc_en && (sel == RSEL_STATUS);
   assign vec_acc    = acc_en && (sel == RSEL_VECTOR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= acc_wdata[NSRC-1:0];
   end

   irq_group_ctrl #(.NGRP(NGRP), .VEC_W(VEC_W)) u_group (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_level),
      .en       (mask_q[NGRP-1:0]),
      .vec_acc  (vec_acc),
      .irq_a    (irq_group),
      .vec_code (vec_code)
   );

   irq_interval_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_en),
      .reload_wr  (reload_wr),
      .reload_val (acc_wdata[CNT_W-1:0]),
      .status_acc (status_acc),
      .gate_en    (mask_q[TMR_GATE_BIT]),
      .reload_q   (reload_q),
      .count_q    (count_q),
      .req_q      (tmr_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_timer <= 1'b0;
      else        irq_timer <= tmr_req & mask_q[TMR_BIT];
   end

   always_comb begin
      acc_rdata = '0;
      if (rd) begin
         case (sel)
            RSEL_MASK:   acc_rdata[NSRC-1:0]  = mask_q;
            RSEL_VECTOR: acc_rdata[VEC_W+1:0] = {vec_code, 2'b00};
            RSEL_RELOAD: acc_rdata[CNT_W-1:0] = reload_q;
            default:     acc_rdata[CNT_W-1:0] = count_q;
         endcase
      end
   end

   assert_timer_needs_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_timer |-> $past(mask_q[TMR_BIT]) && $past(tmr_req));
   assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> mask_q == $past(acc_wdata[NSRC-1:0]));
   assert_idle_rdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> acc_rdata == '0);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   localparam int NSRC = 16, CNT_W = 16, PEND_W = 3, DATA_W = 16;
   localparam int PMAX = (1 << PEND_W) - 1;

   logic              clk = 0, rst_n = 0;
   logic [NSRC-2:0]   src_level = '0;
   logic              tick_en = 0, acc_en = 0, acc_wr = 0;
   logic [1:0]        acc_addr = 0;
   logic [DATA_W-1:0] acc_wdata = 0;
   logic [DATA_W-1:0] acc_rdata;
   logic              irq_group, irq_timer;

   int checks = 0, failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl #(.NSRC(NSRC), .CNT_W(CNT_W), .PEND_W(PEND_W), .DATA_W(DATA_W),
                   .TMR_GATE_BIT(1)) u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_level(src_level), .tick_en(tick_en),
      .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .irq_group(irq_group), .irq_timer(irq_timer));

   // behavioural reference model
   int m_mask, m_prev, m_R, m_C, m_P;
   bit m_A, m_B, m_req;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask = 0; m_prev = 0; m_R = 0; m_C = 0; m_P = 0;
         m_A = 0; m_B = 0; m_req = 0;
      end else begin
         int grp, nR, nC, nP, nmask;
         bit nA, nB, nreq, vacc, sacc, rw;
         vacc = acc_en && acc_addr == 1;
         sacc = acc_en && acc_addr == 3;
         rw   = acc_en && acc_wr && acc_addr == 2;
         grp  = int'(src_level) & m_mask & 'h7FFF;
         nA   = vacc ? 0 : (grp != m_prev) ? (grp != 0) : m_A;
         nB   = m_req && m_mask[15];
         nreq = sacc ? 0 : (m_P != 0 && m_R != 0 && m_mask[1]) ? 1 : m_req;
         nR = m_R; nC = m_C; nP = m_P;
         nmask = (acc_en && acc_wr && acc_addr == 0) ? int'(acc_wdata) : m_mask;
         if (rw) begin
            nR = int'(acc_wdata); nC = int'(acc_wdata);
         end else if (sacc) begin
            nC = m_R; if (m_P > 0) nP = m_P - 1;
         end else if (tick_en && m_R != 0) begin
            if (m_C <= 1) begin nC = m_R; if (m_P < PMAX) nP = m_P + 1; end
            else nC = m_C - 1;
         end
         m_prev = grp; m_A = nA; m_B = nB; m_req = nreq;
         m_R = nR; m_C = nC; m_P = nP; m_mask = nmask;
      end
   end

   function automatic int exp_read(int a);
      int v;
      case (a)
         0: return m_mask;
         1: begin
            v = 0;
            for (int i = 14; i >= 0; i--) if (src_level[i]) v = (i + 1) << 2;
            return v;
         end
         2: return m_R;
         default: return m_C;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: check read data mid-cycle, then outputs after the edge
   task automatic cyc(string tag);
      #1;
      if (acc_en && !acc_wr) chk({tag, " rdata"}, int'(acc_rdata), exp_read(int'(acc_addr)));
      @(posedge clk);
      @(negedge clk);
      chk({tag, " irq_group"}, int'(irq_group), int'(m_A));
      chk({tag, " irq_timer"}, int'(irq_timer), int'(m_B));
      acc_en = 0; acc_wr = 0; tick_en = 0;
   endtask

   task automatic acc(string tag, bit wr, int a, int d);
      acc_en = 1; acc_wr = wr; acc_addr = 2'(a); acc_wdata = DATA_W'(d);
      cyc(tag);
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   task automatic read_exp(string tag, int a, int exp);
      acc_en = 1; acc_wr = 0; acc_addr = 2'(a);
      #1 chk({tag, " explicit"}, int'(acc_rdata), exp);
      cyc(tag);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 irq_group", int'(irq_group), 0);
      chk("R11 irq_timer", int'(irq_timer), 0);
      read_exp("R11 mask", 0, 0);
      read_exp("R11 reload", 2, 0);
      read_exp("R11 count", 3, 0);

      // R3 / R1 / R4 / R5 group path
      acc("R3 mask wr", 1, 0, 'h7FFF);
      read_exp("R3 mask rd", 0, 'h7FFF);
      src_level = 15'(1 << 5);
      idle("R1 rise", 2);
      chk("R1 explicit", int'(irq_group), 1);
      read_exp("R4 vec idx5", 1, 24);
      chk("R5 explicit", int'(irq_group), 0);
      idle("R5 stays low", 3);
      chk("R5 still low", int'(irq_group), 0);
      acc("R3 same mask", 1, 0, 'h7FFF);
      idle("R3 hold", 2);
      chk("R3 hold explicit", int'(irq_group), 0);
      src_level = 15'((1 << 5) | (1 << 2));
      idle("R1 new src", 2);
      chk("R1 explicit2", int'(irq_group), 1);
      read_exp("R4 vec idx2", 1, 12);
      acc("R5 vec write", 1, 1, 0);
      chk("R5 wr explicit", int'(irq_group), 0);
      src_level = 15'(1 << 14);
      acc("R3 mask off", 1, 0, 'h3FFF);
      read_exp("R4 unmasked", 1, 60);
      idle("R3 masked off", 2);
      chk("R3 off explicit", int'(irq_group), 0);
      src_level = '0;
      read_exp("R4 none", 1, 0);

      // timer: R6 R7 R8 R2 R9
      acc("R3 timer mask", 1, 0, 'h8002);
      acc("R6 reload wr", 1, 2, 5);
      read_exp("R6 reload rd", 2, 5);
      tick_en = 1; cyc("R7 tick");
      tick_en = 1; cyc("R7 tick");
      read_exp("R7 count", 3, 3);
      acc("R6 reload 3", 1, 2, 3);
      for (int i = 0; i < 3; i++) begin tick_en = 1; cyc("R7 expire"); end
      idle("R9 raise", 2);
      chk("R2 explicit", int'(irq_timer), 1);
      read_exp("R8 status", 3, 3);
      idle("R8 clear", 2);
      chk("R8 explicit", int'(irq_timer), 0);

      // R10 saturation: 10 expiries, only PMAX retained
      for (int i = 0; i < 30; i++) begin tick_en = 1; cyc("R10 ticks"); end
      for (int k = 0; k < PMAX - 1; k++) begin acc("R10 ack", 0, 3, 0); idle("R10 gap", 1); end
      idle("R10 gap", 2);
      chk("R10 still pending", int'(irq_timer), 1);
      acc("R10 last ack", 0, 3, 0);
      idle("R10 drained", 3);
      chk("R10 drained explicit", int'(irq_timer), 0);

      // R9 gating by mask bit 1
      acc("R9 ungate", 1, 0, 'h8000);
      for (int i = 0; i < 4; i++) begin tick_en = 1; cyc("R9 gated ticks"); end
      idle("R9 gated", 3);
      chk("R9 gated explicit", int'(irq_timer), 0);
      acc("R9 gate on", 1, 0, 'h8002);
      idle("R9 gate on", 3);
      chk("R9 gate explicit", int'(irq_timer), 1);
      acc("R2 mask15 off", 1, 0, 'h0002);
      idle("R2 masked", 2);
      chk("R2 masked explicit", int'(irq_timer), 0);

      // pseudo-random run against the model
      lfsr = 32'hACE1_2357;
      for (int n = 0; n < 4000; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[3:0] == 0) src_level = 15'(lfsr[30:16]);
         tick_en = lfsr[5];
         if (lfsr[9:7] == 0) begin
            acc_en = 1; acc_wr = lfsr[10]; acc_addr = lfsr[12:11];
            acc_wdata = (lfsr[12:11] == 2) ? DATA_W'(lfsr[15:13]) : DATA_W'(lfsr[31:16]);
         end
         cyc("R1 R2 R7 R8 R9 R10 random");
      end

      done = 1;
      summary();
      $finish;
   end
endmodule